// File: doc/BRIEF.md
# Serial Row/Column Address and Mode Loader

This block collects memory addresses that arrive one bit at a time on a single serial pin, so that a sequential-access memory needs few package pins for addressing. Each serial word is eight bits long and enters least significant bit first, one bit for each cycle in which the bit strobe is high. When the eighth bit arrives, the assembled word goes to one of two parallel holding registers. A select input, sampled with that eighth bit, chooses which one: the row register or the column register.

The column word packs a six-bit column address together with a two-bit operation code. The held row, column and operation feed the array decoders. When an access strobe arrives, the block issues a one-cycle command pulse: write transfer, read transfer or refresh. A row value beyond the last physical row sets an error flag, and no command is issued while that flag is set.

Top module: `serial_addr_loader`

## Requirements
- R1: After reset, row_addr, col_addr and mode are all zero, row_err is low, all three command pulses are low, and the bit counter starts at zero.
- R2: Serial bits are taken only in cycles with bit_stb high, and the first bit taken becomes bit 0 of the word. The eighth bit taken completes the word. The held outputs show the new word two clock cycles after the cycle that carried the eighth bit.
- R3: If sel_col is high in the cycle of the eighth bit, the word loads the column register; if it is low, the word loads the row register. The register that is not selected keeps its value.
- R4: In a column word, bits 5..0 appear on col_addr and bits 7..6 appear on mode.
- R5: After each completed word the bit counter starts again from zero. Cycles with bit_stb low shift nothing, whatever bit_in carries.
- R6: Loading a row value of 212 or more sets row_err. Loading a row value below 212 clears it.
- R7: An access strobe produces a one-cycle pulse in the following cycle, chosen by mode: do_wr for mode 2'b10, do_rd for mode 2'b01, do_ref for mode 2'b00. Mode 2'b11 produces no pulse. At most one pulse is high at a time.
- R8: While row_err is high, an access strobe produces no command pulse.
- R9: If an access strobe falls in the same cycle in which a completed word is written into a holding register, the command pulse is decided by the values held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Address clock enable: take bit_in this cycle |
| bit_in | input | 1 | Serial address bit, least significant first |
| sel_col | input | 1 | Target of the word completed this cycle: 1 column, 0 row |
| acc_stb | input | 1 | Memory access strobe |
| row_addr | output | 8 | Held row address |
| col_addr | output | 6 | Held column address |
| mode | output | 2 | Held operation code |
| row_err | output | 1 | Held row is out of range |
| do_wr | output | 1 | Write transfer command pulse |
| do_rd | output | 1 | Read transfer command pulse |
| do_ref | output | 1 | Refresh command pulse |

## Verification
Two events can fall in the same cycle: a completed word being written into a holding register, and an access strobe that decodes the held values. The bench provokes this by raising acc_stb in exactly the cycle that follows the eighth serial bit, which is the cycle in which the register update takes effect. The check passes when the command pulse matches the operation and row error held before the update, while the held outputs already show the new word. Random words, targets and strobe gaps are also checked against a bench model of the two holding registers.

// File: rtl/sal_pkg.sv
package sal_pkg;
  typedef enum logic [1:0] {
    MODE_REF = 2'b00,
    MODE_RD  = 2'b01,
    MODE_WR  = 2'b10,
    MODE_NOP = 2'b11
  } sal_mode_e;
endpackage

// File: rtl/sal_shift.sv
module sal_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              sel_col,
  output logic [WORD_W-1:0] word_q,
  output logic              word_stb_q,
  output logic              word_sel_q
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] sr_next;

  assign sr_next = {bit_in, sr[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      sr         <= '0;
      word_q     <= '0;
      word_stb_q <= 1'b0;
      word_sel_q <= 1'b0;
    end else begin
      word_stb_q <= 1'b0;
      if (bit_stb) begin
        sr <= sr_next;
        if (cnt == LAST) begin
          cnt        <= '0;
          word_q     <= sr_next;
          word_stb_q <= 1'b1;
          word_sel_q <= sel_col;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: counter restarts after a completed word
  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && cnt == LAST) |=> (cnt == '0 && word_stb_q));

  // R5: idle cycles leave the counter untouched
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(cnt));
endmodule

// File: rtl/sal_latch.sv
module sal_latch #(
  parameter int WORD_W = 8,
  parameter int ROWS   = 212
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              word_stb,
  input  logic              word_sel,
  output logic [WORD_W-1:0] row_q,
  output logic [WORD_W-1:0] colw_q,
  output logic              row_err_q
);
  localparam logic [WORD_W:0] ROW_LIM = (WORD_W+1)'(ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q     <= '0;
      colw_q    <= '0;
      row_err_q <= 1'b0;
    end else if (word_stb) begin
      if (word_sel) begin
        colw_q <= word;
      end else begin
        row_q     <= word;
        row_err_q <= ({1'b0, word} >= ROW_LIM);
      end
    end
  end

  // R3: holding registers change only on a completed word
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !word_stb |=> ($stable(row_q) && $stable(colw_q) && $stable(row_err_q)));

  // R3: a column load leaves the row side alone
  p_col_keeps_row_r3: assert property (@(posedge clk) disable iff (rst)
    (word_stb && word_sel) |=> $stable(row_q));
endmodule

// File: rtl/sal_access.sv
module sal_access
  import sal_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc_stb,
  input  sal_mode_e mode,
  input  logic      row_err,
  output logic      do_wr,
  output logic      do_rd,
  output logic      do_ref
);
  logic go;
  assign go = acc_stb && !row_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      do_wr  <= 1'b0;
      do_rd  <= 1'b0;
      do_ref <= 1'b0;
    end else begin
      do_wr  <= go && (mode == MODE_WR);
      do_rd  <= go && (mode == MODE_RD);
      do_ref <= go && (mode == MODE_REF);
    end
  end

  // R7: never more than one command at a time
  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_wr, do_rd, do_ref}));

  // R7: a command pulse lasts one cycle unless strobed again
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_stb |=> !(do_wr || do_rd || do_ref));

  // R8: out-of-range row blocks every command
  p_err_block_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && row_err) |=> !(do_wr || do_rd || do_ref));
endmodule

// File: rtl/serial_addr_loader.sv
module serial_addr_loader
  import sal_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ROWS   = 212
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              sel_col,
  input  logic              acc_stb,
  output logic [WORD_W-1:0] row_addr,
  output logic [WORD_W-3:0] col_addr,
  output logic [1:0]        mode,
  output logic              row_err,
  output logic              do_wr,
  output logic              do_rd,
  output logic              do_ref
);
  localparam int COL_W = WORD_W - 2;

  logic [WORD_W-1:0] word;
  logic              word_stb;
  logic              word_sel;
  logic [WORD_W-1:0] colw;
  sal_mode_e         mode_e;

  sal_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .bit_in     (bit_in),
    .sel_col    (sel_col),
    .word_q     (word),
    .word_stb_q (word_stb),
    .word_sel_q (word_sel)
  );

  sal_latch #(.WORD_W(WORD_W), .ROWS(ROWS)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .word      (word),
    .word_stb  (word_stb),
    .word_sel  (word_sel),
    .row_q     (row_addr),
    .colw_q    (colw),
    .row_err_q (row_err)
  );

  assign col_addr = colw[COL_W-1:0];
  assign mode     = colw[WORD_W-1:WORD_W-2];
  assign mode_e   = sal_mode_e'(mode);

  sal_access u_access (
    .clk     (clk),
    .rst     (rst),
    .acc_stb (acc_stb),
    .mode    (mode_e),
    .row_err (row_err),
    .do_wr   (do_wr),
    .do_rd   (do_rd),
    .do_ref  (do_ref)
  );

  // R1: reset clears the held state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (row_addr == '0 && col_addr == '0 && mode == 2'b00 && !row_err));
endmodule

// File: tb/serial_addr_loader_tb.sv
module serial_addr_loader_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, bit_stb, bit_in, sel_col, acc_stb;
  logic [7:0] row_addr;
  logic [5:0] col_addr;
  logic [1:0] mode;
  logic row_err, do_wr, do_rd, do_ref;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_row, m_colw;

  always #(CLK_P/2) clk = ~clk;

  serial_addr_loader u_dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .sel_col(sel_col), .acc_stb(acc_stb), .row_addr(row_addr),
    .col_addr(col_addr), .mode(mode), .row_err(row_err),
    .do_wr(do_wr), .do_rd(do_rd), .do_ref(do_ref)
  );

  function automatic logic exp_err(input logic [7:0] r);
    return r >= 8'd212;
  endfunction

  function automatic logic [2:0] exp_cmd(input logic [7:0] colw, input logic [7:0] r);
    if (exp_err(r)) return 3'b000;
    case (colw[7:6])
      2'b10:   return 3'b100;
      2'b01:   return 3'b010;
      2'b00:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_held(input string req);
    chk({req, " row"}, 32'(row_addr), 32'(m_row));
    chk({req, " col"}, 32'(col_addr), 32'(m_colw[5:0]));
    chk({req, " mode"}, 32'(mode), 32'(m_colw[7:6]));
    chk({req, " err"}, 32'(row_err), 32'(exp_err(m_row)));
  endtask

  task automatic shift_bits(input logic [7:0] w, input logic sel, input bit gaps);
    for (int i = 0; i < 8; i++) begin
      if (gaps) begin
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          bit_stb = 1'b0;
          bit_in  = 1'($urandom);
          sel_col = 1'($urandom);
        end
      end
      @(negedge clk);
      bit_stb = 1'b1;
      bit_in  = w[i];
      sel_col = (i == 7) ? sel : 1'($urandom);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input logic sel, input bit gaps);
    shift_bits(w, sel, gaps);
    @(negedge clk);
    bit_stb = 1'b0;
    @(negedge clk);
    if (sel) m_colw = w; else m_row = w;
  endtask

  task automatic access(input string req);
    logic [2:0] e;
    e = exp_cmd(m_colw, m_row);
    @(negedge clk);
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    chk(req, 32'({do_wr, do_rd, do_ref}), 32'(e));
    @(negedge clk);
    chk({req, " one cycle"}, 32'({do_wr, do_rd, do_ref}), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] e_old;
    void'($urandom(32'd1234));
    rst = 1'b1; bit_stb = 1'b0; bit_in = 1'b0; sel_col = 1'b0; acc_stb = 1'b0;
    m_row = 8'h00; m_colw = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_held("R1 reset");
    chk("R1 cmd", 32'({do_wr, do_rd, do_ref}), 32'd0);

    // R2 timing: nothing before second edge after eighth bit
    shift_bits(8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    bit_stb = 1'b0;
    chk("R2 not yet", 32'(row_addr), 32'h00);
    @(negedge clk);
    m_row = 8'h5A;
    chk("R2 row lsb first", 32'(row_addr), 32'h5A);

    // R3/R4 column load leaves row
    send_word(8'b10_101011, 1'b1, 1'b0);
    chk_held("R3 R4 col");
    access("R7 write");

    send_word(8'b01_000111, 1'b1, 1'b1);
    chk_held("R5 gaps");
    access("R7 read");
    send_word(8'b00_111111, 1'b1, 1'b0);
    access("R7 refresh");
    send_word(8'b11_010101, 1'b1, 1'b0);
    access("R7 reserved");

    // R6 boundaries
    send_word(8'b10_000001, 1'b1, 1'b0);
    send_word(8'd211, 1'b0, 1'b0);
    chk("R6 row 211", 32'(row_err), 32'd0);
    access("R7 write at 211");
    send_word(8'd212, 1'b0, 1'b0);
    chk("R6 row 212", 32'(row_err), 32'd1);
    access("R8 blocked 212");
    send_word(8'd255, 1'b0, 1'b1);
    chk("R6 row 255", 32'(row_err), 32'd1);
    chk_held("R3 col kept");
    access("R8 blocked 255");
    send_word(8'd3, 1'b0, 1'b0);
    chk("R6 clear", 32'(row_err), 32'd0);

    // R9 same cycle: old values decide
    e_old = exp_cmd(m_colw, m_row);
    shift_bits(8'b01_001100, 1'b1, 1'b0);
    @(negedge clk);
    bit_stb = 1'b0;
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    chk("R9 old cmd", 32'({do_wr, do_rd, do_ref}), 32'(e_old));
    m_colw = 8'b01_001100;
    chk_held("R9 new held");

    e_old = exp_cmd(m_colw, m_row);
    shift_bits(8'd230, 1'b0, 1'b0);
    @(negedge clk);
    bit_stb = 1'b0;
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    chk("R9 old row ok", 32'({do_wr, do_rd, do_ref}), 32'(e_old));
    m_row = 8'd230;
    chk_held("R9 err now");

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [7:0] w;
      logic s;
      w = 8'($urandom);
      s = 1'($urandom);
      send_word(w, s, 1'($urandom));
      chk_held("R2 R3 R5 random");
      if ($urandom_range(0, 1) == 1) access("R7 R8 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule